// File: doc/BRIEF.md
# UART RTS/CTS Flow Control Unit

This unit runs the hardware handshake of a serial port. On the receive side it compares the fill count of the receive FIFO with two programmed levels. It drops the request-to-send pin when the FIFO nears full. It raises the pin again only once the FIFO has drained well below that point. Because the two levels are separate, the pin does not toggle on every byte near one boundary.

On the transmit side it gates the transmitter's start request with the clear-to-send pin. That pin first passes through a synchronizer. A character is allowed to start only while the far end reports it can accept data. Auto-RTS and auto-CTS have separate enables and can be used in any combination. With auto-RTS off, the pin follows a software modem-control bit.

The threshold byte holds two 4-bit fields. The low nibble sets the halt level and the high nibble sets the resume level. Each field is scaled by four, which gives 0 to 60 FIFO entries. While the FIFOs are disabled, the unit behaves as if the halt level were one byte.

Top module: `fc_flow_ctrl`

## Requirements
- R1: With auto-RTS enabled, `rts_no` is high (inactive) one clock after `rx_level_i` is at or above the halt level. The halt level is `thr_i[3:0]*4`.
- R2: With auto-RTS enabled and not halted, `rts_no` stays low (active) while the level is below the halt level.
- R3: After a halt, `rts_no` returns low one clock after the level is at or below the resume level, `thr_i[7:4]*4`. While the level lies strictly between the resume and halt levels, `rts_no` holds its value.
- R4: A level above the halt level keeps `rts_no` high. This covers the extra byte the far end may still send after RTS drops.
- R5: With auto-RTS disabled, `rts_no` equals `~sw_rts_i` one clock later, and the halted state is cleared. After auto-RTS is re-enabled with the level inside the band, RTS stays active.
- R6: While `fifo_en_i` is 0, the halt level is 1 and the resume level is 0.
- R7: With auto-CTS enabled, `tx_permit_o` is `tx_req_i` AND (synchronized `cts_ni` low). With auto-CTS disabled, `tx_permit_o` equals `tx_req_i`.
- R8: A change on `cts_ni` reaches `tx_permit_o` after exactly two rising clock edges.
- R9: During and after reset, `rts_no` is 1 and the synchronized CTS reads inactive.
- R10: `tx_permit_o` is never high while `tx_req_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| auto_rts_en_i | input | 1 | Enable FIFO-driven RTS |
| auto_cts_en_i | input | 1 | Enable CTS gating of transmit starts |
| fifo_en_i | input | 1 | FIFOs enabled; 0 forces halt level 1, resume level 0 |
| thr_i | input | 8 | [3:0] halt field, [7:4] resume field, each times 4 |
| rx_level_i | input | 7 | Receive FIFO fill count, 0..64 |
| sw_rts_i | input | 1 | Software RTS bit, 1 = assert RTS |
| cts_ni | input | 1 | Clear-to-send pin, active low, asynchronous |
| tx_req_i | input | 1 | Transmitter ready to start a character |
| rts_no | output | 1 | Request-to-send pin, active low |
| tx_permit_o | output | 1 | Transmitter may start a character |

## Verification
The hardest state to reach is the hysteresis band. To be there, RTS must have been pushed inactive by crossing the halt level, and the level must then fall without yet reaching the resume level. The stimulus table walks the level up past the halt point, one entry beyond it, and back down through the band in order. A second pass re-enables auto-RTS with the level already inside the band, to show that a disable clears the halted state.

// File: rtl/fc_pkg.sv
package fc_pkg;
  localparam int unsigned FIFO_DEPTH_DEF = 64;
  localparam int unsigned THR_SCALE_DEF  = 4;
  localparam int unsigned SYNC_DEF       = 2;

  typedef enum logic {
    RTS_FLOW = 1'b0,
    RTS_HALT = 1'b1
  } rts_state_e;
endpackage

// File: rtl/fc_sync.sv
module fc_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[g] <= RESET_VAL;
        else if (g == 0) chain_q[g] <= d_i;
        else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/fc_rts_ctrl.sv
module fc_rts_ctrl
  import fc_pkg::*;
#(
  parameter int unsigned LVL_W     = 7,
  parameter int unsigned THR_SHIFT = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             auto_en_i,
  input  logic             fifo_en_i,
  input  logic [7:0]       thr_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic             sw_rts_i,
  output logic             rts_no
);
  logic [LVL_W-1:0] halt_lvl, resume_lvl;
  rts_state_e       state_q, state_d;
  logic             rts_q;

  always_comb begin
    if (fifo_en_i) begin
      halt_lvl   = LVL_W'(thr_i[3:0]) << THR_SHIFT;
      resume_lvl = LVL_W'(thr_i[7:4]) << THR_SHIFT;
    end else begin
      halt_lvl   = LVL_W'(1);
      resume_lvl = '0;
    end
  end

  always_comb begin
    state_d = state_q;
    if (!auto_en_i)                state_d = RTS_FLOW;
    else if (level_i >= halt_lvl)  state_d = RTS_HALT;
    else if (level_i <= resume_lvl) state_d = RTS_FLOW;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RTS_FLOW;
      rts_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      rts_q   <= auto_en_i ? (state_d == RTS_HALT) : ~sw_rts_i;
    end
  end

  assign rts_no = rts_q;

  // R1
  rts_halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    auto_en_i && (level_i >= halt_lvl) |=> rts_no);

  // R3
  rts_resume_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    auto_en_i && (level_i < halt_lvl) && (level_i <= resume_lvl) |=> !rts_no);

  // R3
  rts_band_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    auto_en_i && $past(auto_en_i) && (level_i > resume_lvl) && (level_i < halt_lvl)
    |=> $stable(rts_no));

  // R5
  rts_sw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !auto_en_i |=> (rts_no == !$past(sw_rts_i)));
endmodule

// File: rtl/fc_cts_gate.sv
module fc_cts_gate (
  input  logic auto_en_i,
  input  logic cts_sync_ni,
  input  logic tx_req_i,
  output logic tx_permit_o
);
  assign tx_permit_o = tx_req_i && (!auto_en_i || !cts_sync_ni);

  // R10
  permit_needs_req_chk: assert final (!tx_permit_o || tx_req_i);
endmodule

// File: rtl/fc_flow_ctrl.sv
module fc_flow_ctrl
  import fc_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH  = FIFO_DEPTH_DEF,
  parameter int unsigned THR_SCALE   = THR_SCALE_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_DEF,
  localparam int unsigned LVL_W      = $clog2(FIFO_DEPTH + 1),
  localparam int unsigned THR_SHIFT  = $clog2(THR_SCALE)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             auto_rts_en_i,
  input  logic             auto_cts_en_i,
  input  logic             fifo_en_i,
  input  logic [7:0]       thr_i,
  input  logic [LVL_W-1:0] rx_level_i,
  input  logic             sw_rts_i,
  input  logic             cts_ni,
  input  logic             tx_req_i,
  output logic             rts_no,
  output logic             tx_permit_o
);
  logic cts_sync_n;

  fc_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_cts_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (cts_ni),
    .q_o   (cts_sync_n)
  );

  fc_rts_ctrl #(.LVL_W(LVL_W), .THR_SHIFT(THR_SHIFT)) u_rts (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .auto_en_i(auto_rts_en_i),
    .fifo_en_i(fifo_en_i),
    .thr_i    (thr_i),
    .level_i  (rx_level_i),
    .sw_rts_i (sw_rts_i),
    .rts_no   (rts_no)
  );

  fc_cts_gate u_cts (
    .auto_en_i  (auto_cts_en_i),
    .cts_sync_ni(cts_sync_n),
    .tx_req_i   (tx_req_i),
    .tx_permit_o(tx_permit_o)
  );

  // R7
  cts_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    auto_cts_en_i && cts_sync_n |-> !tx_permit_o);

  // R8
  cts_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni, 2) |-> (cts_sync_n == $past(cts_ni, 2)));
endmodule

// File: tb/sim_fc_flow_ctrl.sv
module sim_fc_flow_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ar, ac, fe, sw, cts_n, req;
  logic [7:0] thr;
  logic [6:0] lvl;
  logic rts_n, permit;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  fc_flow_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .auto_rts_en_i(ar), .auto_cts_en_i(ac),
    .fifo_en_i(fe), .thr_i(thr), .rx_level_i(lvl), .sw_rts_i(sw),
    .cts_ni(cts_n), .tx_req_i(req), .rts_no(rts_n), .tx_permit_o(permit)
  );

  typedef struct packed {
    logic ar, ac, fe;
    logic [7:0] thr;
    logic [6:0] lvl;
    logic sw, cts_n, req, e_rts, e_perm;
  } vec_t;

  // thr 8'h24: halt 16, resume 8; 8'h9F: halt 60, resume 36
  localparam vec_t VECS [19] = '{
    '{1'b1,1'b0,1'b1,8'h24,7'd0 ,1'b0,1'b1,1'b1,1'b0,1'b1}, // R2
    '{1'b1,1'b0,1'b1,8'h24,7'd15,1'b0,1'b1,1'b1,1'b0,1'b1}, // R2
    '{1'b1,1'b0,1'b1,8'h24,7'd16,1'b0,1'b1,1'b1,1'b1,1'b1}, // R1
    '{1'b1,1'b0,1'b1,8'h24,7'd17,1'b0,1'b1,1'b1,1'b1,1'b1}, // R4
    '{1'b1,1'b0,1'b1,8'h24,7'd12,1'b0,1'b1,1'b1,1'b1,1'b1}, // R3
    '{1'b1,1'b0,1'b1,8'h24,7'd9 ,1'b0,1'b1,1'b1,1'b1,1'b1}, // R3
    '{1'b1,1'b0,1'b1,8'h24,7'd8 ,1'b0,1'b1,1'b1,1'b0,1'b1}, // R3
    '{1'b1,1'b0,1'b1,8'h24,7'd12,1'b0,1'b1,1'b1,1'b0,1'b1}, // R3
    '{1'b1,1'b1,1'b1,8'h24,7'd12,1'b0,1'b1,1'b1,1'b0,1'b0}, // R7
    '{1'b1,1'b1,1'b1,8'h24,7'd12,1'b0,1'b0,1'b1,1'b0,1'b1}, // R7
    '{1'b1,1'b1,1'b1,8'h24,7'd12,1'b0,1'b0,1'b0,1'b0,1'b0}, // R10
    '{1'b0,1'b0,1'b1,8'h24,7'd40,1'b1,1'b1,1'b1,1'b0,1'b1}, // R5
    '{1'b0,1'b0,1'b1,8'h24,7'd40,1'b0,1'b1,1'b1,1'b1,1'b1}, // R5
    '{1'b1,1'b0,1'b1,8'h9F,7'd40,1'b0,1'b1,1'b1,1'b0,1'b1}, // R5
    '{1'b1,1'b0,1'b1,8'h9F,7'd60,1'b0,1'b1,1'b1,1'b1,1'b1}, // R1
    '{1'b1,1'b0,1'b0,8'h9F,7'd0 ,1'b0,1'b1,1'b1,1'b0,1'b1}, // R6
    '{1'b1,1'b0,1'b0,8'h9F,7'd1 ,1'b0,1'b1,1'b1,1'b1,1'b1}, // R6
    '{1'b1,1'b0,1'b0,8'h9F,7'd0 ,1'b0,1'b1,1'b1,1'b0,1'b1}, // R6
    '{1'b0,1'b1,1'b1,8'h24,7'd0 ,1'b1,1'b1,1'b1,1'b0,1'b0}  // R7
  };

  task automatic check(input string req_tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req_tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    #400000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    {ar, ac, fe, sw, req} = '0;
    cts_n = 1'b1; thr = 8'h00; lvl = '0;
    #5;
    check("R9 rts in reset", rts_n, 1'b1);
    @(negedge clk); rst_n = 1'b1;
    step(1);
    check("R9 rts after reset", rts_n, 1'b1);
    // sync reads inactive: auto-CTS on, pin held low but not yet through
    ac = 1'b1; req = 1'b1; cts_n = 1'b0;
    check("R9 cts sync inactive", permit, 1'b0);

    for (int i = 0; i < 19; i++) begin
      {ar, ac, fe, thr, lvl, sw, cts_n, req} =
        {VECS[i].ar, VECS[i].ac, VECS[i].fe, VECS[i].thr, VECS[i].lvl,
         VECS[i].sw, VECS[i].cts_n, VECS[i].req};
      step(3);
      check($sformatf("R1-3 vec %0d rts", i), rts_n, VECS[i].e_rts);
      check($sformatf("R7 vec %0d permit", i), permit, VECS[i].e_perm);
    end

    // R8: two-edge CTS latency
    ar = 1'b0; ac = 1'b1; req = 1'b1; cts_n = 1'b1;
    step(3);
    cts_n = 1'b0;
    step(1);
    check("R8 one edge", permit, 1'b0);
    step(1);
    check("R8 two edges", permit, 1'b1);
    cts_n = 1'b1;
    step(1);
    check("R8 release one edge", permit, 1'b1);
    step(1);
    check("R8 release two edges", permit, 1'b0);

    // R10: no request, auto-CTS off
    ac = 1'b0; req = 1'b0;
    step(1);
    check("R10 no req", permit, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule